// File: doc/BRIEF.md
# Program Memory Region Selector

This block sits beside the program counter and the table-access pointer of a small processor whose program space is 21 bits wide (byte addresses 0x000000 to 0x1FFFFF). For every program-memory access it says whether the bytes come from on-chip flash or from the external memory bus. It also flags reads that must come back as zero, and it sets how the pins shared between the external bus and general-purpose I/O behave.

A 2-bit memory mode picks one of four memory maps. In internal-only mode everything stays on chip, and reads past the last flash byte return zero, which the core runs as a no-operation. In external-only mode the on-chip flash is never used. In boot-block mode only a small block at the bottom of the space is on chip. In extended mode all of the flash is on chip up to a boundary, and everything above it is external. The last flash address and the boot-block size are parameters. The region select and the zero-read flag are combinational from the address and the mode. The pin state is held in a register and follows the inputs one clock later, so the pins never see decode glitches.

A bus-disable input matters only in the two mixed modes, and only while the access is internal. When it is high the pins become I/O. When it is low the external bus keeps the pins, but its address/data lines float and its control strobes sit at their inactive levels.

Top module: `pmrs_top`

## Requirements
- R1: With mode 2'b11 (internal-only), ext_sel is 0 for every address.
- R2: zero_read is 1 exactly when mode is 2'b11 and the address is greater than FLASH_LAST; in every other mode it is 0.
- R3: With mode 2'b10 (external-only), ext_sel is 1 for every address, address 0 included.
- R4: With mode 2'b01 (boot block), ext_sel is 0 for addresses below BOOT_BYTES and 1 from BOOT_BYTES up to 0x1FFFFF.
- R5: With mode 2'b00 (extended), ext_sel is 0 for addresses up to and including FLASH_LAST and 1 from FLASH_LAST+1 up to 0x1FFFFF.
- R6: The pin state {pin_io, bus_drive, ctl_park} takes the value decided by the inputs present at a rising clock edge and holds it until the next edge. While rst_n is low the pin state is I/O (1,0,0).
- R7: With mode 2'b11 the pin state is I/O, whatever bus_dis is.
- R8: With mode 2'b10 the pin state is bus-driving (0,1,0), whatever bus_dis is.
- R9: In mode 2'b01 or 2'b00, an external access gives bus-driving, whatever bus_dis is.
- R10: In mode 2'b01 or 2'b00, an internal access with bus_dis=1 gives I/O.
- R11: In mode 2'b01 or 2'b00, an internal access with bus_dis=0 gives parked (0,0,1): address/data lines float and the control strobes are inactive.
- R12: Exactly one of pin_io, bus_drive and ctl_park is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pin-state register |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Memory map: 00 extended, 01 boot block, 10 external-only, 11 internal-only |
| addr | input | 21 | Byte address of the current program-memory access |
| bus_dis | input | 1 | Bus-disable control; acts only on internal accesses in mixed modes |
| ext_sel | output | 1 | 1 = access goes to the external bus, 0 = on-chip flash |
| zero_read | output | 1 | 1 = the read must return all zeros |
| pin_io | output | 1 | Shared pins act as general-purpose I/O |
| bus_drive | output | 1 | External bus drives address/data and control |
| ctl_park | output | 1 | Bus keeps the pins, address/data floating, strobes inactive |

## Verification
The hardest situation to reach from the ports is a mixed mode where the access moves across the region edge while bus_dis is held. The pin state then has to swap between parked or I/O and bus-driving purely because of the address, with the change one clock late. The bench drives address pairs that straddle FLASH_LAST/FLASH_LAST+1 and BOOT_BYTES-1/BOOT_BYTES, under both bus_dis values. It checks the combinational select right after the change. It also checks that the pins still show the old state before the next edge, and the new state after it.

// File: rtl/pmrs_pkg.sv
package pmrs_pkg;

    typedef enum logic [1:0] {
        MODE_EXTENDED = 2'b00,
        MODE_BOOTBLK  = 2'b01,
        MODE_EXTONLY  = 2'b10,
        MODE_INTONLY  = 2'b11
    } pm_mode_e;

    typedef struct packed {
        logic pin_io;
        logic bus_drive;
        logic ctl_park;
        logic started;
    } pin_state_t;

endpackage

// File: rtl/pmrs_region.sv
module pmrs_region
    import pmrs_pkg::*;
#(
    parameter int                ADDR_W     = 21,
    parameter logic [ADDR_W-1:0] FLASH_LAST = 21'h01FFFF,
    parameter logic [ADDR_W-1:0] BOOT_BYTES = 21'h000800
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              ext_sel,
    output logic              zero_read
);

    logic above_flash;
    logic in_boot;

    assign above_flash = (addr > FLASH_LAST);
    assign in_boot     = (addr < BOOT_BYTES);

    always_comb begin
        ext_sel   = 1'b0;
        zero_read = 1'b0;
        unique case (pm_mode_e'(mode))
            MODE_INTONLY: begin
                ext_sel   = 1'b0;
                zero_read = above_flash;
            end
            MODE_EXTONLY:  ext_sel = 1'b1;
            MODE_BOOTBLK:  ext_sel = !in_boot;
            MODE_EXTENDED: ext_sel = above_flash;
            default:       ext_sel = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmrs_pinctl.sv
module pmrs_pinctl
    import pmrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ext_sel,
    input  logic       bus_dis,
    output logic       pin_io,
    output logic       bus_drive,
    output logic       ctl_park
);

    pin_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.started = 1'b1;
        if (pm_mode_e'(mode) == MODE_INTONLY) begin
            st_d.pin_io    = 1'b1;
            st_d.bus_drive = 1'b0;
            st_d.ctl_park  = 1'b0;
        end else if (pm_mode_e'(mode) == MODE_EXTONLY || ext_sel) begin
            st_d.pin_io    = 1'b0;
            st_d.bus_drive = 1'b1;
            st_d.ctl_park  = 1'b0;
        end else if (bus_dis) begin
            st_d.pin_io    = 1'b1;
            st_d.bus_drive = 1'b0;
            st_d.ctl_park  = 1'b0;
        end else begin
            st_d.pin_io    = 1'b0;
            st_d.bus_drive = 1'b0;
            st_d.ctl_park  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pin_io: 1'b1, bus_drive: 1'b0, ctl_park: 1'b0, started: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_io    = st_q.pin_io;
    assign bus_drive = st_q.bus_drive;
    assign ctl_park  = st_q.ctl_park;

    assert_one_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pin_io, bus_drive, ctl_park}) == 1);

    assert_intonly_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started && $past(mode) == 2'b11 |-> pin_io);

    assert_extonly_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started && $past(mode) == 2'b10 |-> bus_drive);

    assert_ext_access_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started && !$past(mode[1]) && $past(ext_sel) |-> bus_drive);

    assert_dis_io_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started && !$past(mode[1]) && !$past(ext_sel) && $past(bus_dis) |-> pin_io);

    assert_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.started && !$past(mode[1]) && !$past(ext_sel) && !$past(bus_dis) |-> ctl_park);

endmodule

// File: rtl/pmrs_top.sv
module pmrs_top
    import pmrs_pkg::*;
#(
    parameter int                ADDR_W     = 21,
    parameter logic [ADDR_W-1:0] FLASH_LAST = 21'h01FFFF,
    parameter logic [ADDR_W-1:0] BOOT_BYTES = 21'h000800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bus_dis,
    output logic              ext_sel,
    output logic              zero_read,
    output logic              pin_io,
    output logic              bus_drive,
    output logic              ctl_park
);

    pmrs_region #(
        .ADDR_W     (ADDR_W),
        .FLASH_LAST (FLASH_LAST),
        .BOOT_BYTES (BOOT_BYTES)
    ) u_region (
        .mode      (mode),
        .addr      (addr),
        .ext_sel   (ext_sel),
        .zero_read (zero_read)
    );

    pmrs_pinctl u_pinctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ext_sel   (ext_sel),
        .bus_dis   (bus_dis),
        .pin_io    (pin_io),
        .bus_drive (bus_drive),
        .ctl_park  (ctl_park)
    );

    assert_intonly_internal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b11 |-> !ext_sel);

    assert_zero_only_intonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
        zero_read |-> (mode == 2'b11 && addr > FLASH_LAST));

    assert_extonly_external_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b10 |-> ext_sel);

    assert_boot_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b01 && addr < BOOT_BYTES |-> !ext_sel);

    assert_extended_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b00 && addr <= FLASH_LAST |-> !ext_sel);

endmodule

// File: tb/sim_pmrs_top.sv
module sim_pmrs_top;

    localparam int          CLK_P = 10;
    localparam logic [20:0] LAST  = 21'h01FFFF;
    localparam logic [20:0] BOOT  = 21'h000800;
    localparam logic [20:0] TOP   = 21'h1FFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b11;
    logic [20:0] addr = '0;
    logic        bus_dis = 1'b0;
    logic        ext_sel, zero_read, pin_io, bus_drive, ctl_park;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pmrs_top #(.ADDR_W(21), .FLASH_LAST(LAST), .BOOT_BYTES(BOOT)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .bus_dis(bus_dis),
        .ext_sel(ext_sel), .zero_read(zero_read),
        .pin_io(pin_io), .bus_drive(bus_drive), .ctl_park(ctl_park)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h (mode=%b addr=%h dis=%b)",
                     req, act, exp, mode, addr, bus_dis);
        end
    endtask

    function automatic logic model_ext(input logic [1:0] m, input logic [20:0] a);
        case (m)
            2'b11:   return 1'b0;
            2'b10:   return 1'b1;
            2'b01:   return a >= BOOT;
            default: return a > LAST;
        endcase
    endfunction

    // pins as {io, drive, park}
    function automatic logic [2:0] model_pins(input logic [1:0] m, input logic [20:0] a, input logic d);
        if (m == 2'b11) return 3'b100;
        if (m == 2'b10 || model_ext(m, a)) return 3'b010;
        if (d) return 3'b100;
        return 3'b001;
    endfunction

    task automatic step(input string rsel, input string rpin,
                        input logic [1:0] m, input logic [20:0] a, input logic d);
        logic [2:0] old_pins;
        @(negedge clk);
        old_pins = {pin_io, bus_drive, ctl_park};
        mode = m; addr = a; bus_dis = d;
        #1;
        chk(rsel, {31'b0, ext_sel}, {31'b0, model_ext(m, a)});
        chk("R2", {31'b0, zero_read}, {31'b0, (m == 2'b11) && (a > LAST)});
        chk("R6", {29'b0, pin_io, bus_drive, ctl_park}, {29'b0, old_pins});
        @(negedge clk);
        chk(rpin, {29'b0, pin_io, bus_drive, ctl_park}, {29'b0, model_pins(m, a, d)});
        chk("R12", $countones({pin_io, bus_drive, ctl_park}), 32'd1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R6", {29'b0, pin_io, bus_drive, ctl_park}, {29'b0, 3'b100});
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_intonly();
        step("R1", "R7", 2'b11, 21'h000000, 1'b0);
        step("R1", "R7", 2'b11, LAST, 1'b1);
        step("R1", "R7", 2'b11, LAST + 21'd1, 1'b0);
        step("R1", "R7", 2'b11, TOP, 1'b1);
    endtask

    task automatic t_extonly();
        step("R3", "R8", 2'b10, 21'h000000, 1'b0);
        step("R3", "R8", 2'b10, 21'h000000, 1'b1);
        step("R3", "R8", 2'b10, TOP, 1'b1);
    endtask

    task automatic t_bootblk();
        step("R4", "R11", 2'b01, 21'h000000, 1'b0);
        step("R4", "R11", 2'b01, BOOT - 21'd1, 1'b0);
        step("R4", "R9",  2'b01, BOOT, 1'b0);
        step("R4", "R10", 2'b01, BOOT - 21'd1, 1'b1);
        step("R4", "R9",  2'b01, BOOT, 1'b1);
        step("R4", "R9",  2'b01, LAST, 1'b1);
        step("R4", "R9",  2'b01, TOP, 1'b0);
    endtask

    task automatic t_extended();
        step("R5", "R11", 2'b00, 21'h000000, 1'b0);
        step("R5", "R11", 2'b00, LAST, 1'b0);
        step("R5", "R9",  2'b00, LAST + 21'd1, 1'b0);
        step("R5", "R10", 2'b00, LAST, 1'b1);
        step("R5", "R9",  2'b00, LAST + 21'd1, 1'b1);
        step("R5", "R9",  2'b00, TOP, 1'b1);
        step("R5", "R10", 2'b00, BOOT, 1'b1);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        mode = 2'b10;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6", {29'b0, pin_io, bus_drive, ctl_park}, {29'b0, 3'b100});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", {29'b0, pin_io, bus_drive, ctl_park}, {29'b0, 3'b010});
    endtask

    initial begin
        t_reset();
        t_intonly();
        t_extonly();
        t_bootblk();
        t_extended();
        t_intonly();
        t_reset_again();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule